// File: doc/BRIEF.md
# Interrupt Lifecycle Tracker

This block holds the lifecycle state of every interrupt source in an interrupt controller. Each source is inactive, pending, active, or active and pending. Peripheral sources enter pending in one of two ways: from their input line, or from a software set-pending word. The first sixteen IDs are software-generated interrupts. They enter pending only through a request strobe, and that request is qualified by a security attribute.

An acknowledge strobe that carries an ID moves a pending source to active. An end-of-interrupt strobe that carries an ID retires the active state. The block outputs two flat vectors, one pending bit and one active bit per ID. A priority arbiter reads these vectors, and so does a register readback path.

For a level source, pending that comes from the input line is kept apart from pending that software latched. A clear-pending write therefore removes only the latched part. A level source also follows its line directly, with no register in between. Edge sources latch every rising transition of the line, sampled on the clock.

Top module: `gic_pend_tracker`

## Requirements
- R1: While reset is held and after its release, with no stimulus and all lines low, every pending and every active bit is 0.
- R2: An edge source becomes pending on a clocked rising transition of its line. A line that stays high produces no further pending after that pending is cleared.
- R3: A level source with no software latch shows pending exactly while its line is high. The pending bit follows the line with no clock edge in between.
- R4: A set-pending write (wr_clear_i=0) with bit b of word w at 1 adds pending to source 32*w+b. An inactive source becomes pending, and an active source becomes active and pending. Bits that map to IDs 0-15 are ignored.
- R5: On an edge source, a clear-pending write (wr_clear_i=1) turns pending into inactive, and active-and-pending into active. It has no effect on a source that is not pending.
- R6: On a level source, a clear-pending write removes only the software-latched pending. The source stays pending while its line is high.
- R7: An acknowledge of a pending ID makes it active and removes its latched pending. It stays active and pending if it is a level source with its line still high. An acknowledge of an ID that is not pending, or that is at or above the source count, changes nothing.
- R8: An end-of-interrupt on an ID turns active into inactive, and active-and-pending into pending.
- R9: The trigger mode of source N is bit 2N+1 of cfg_i, where 1 selects edge and 0 selects level. Bit 2N has no effect.
- R10: A request for software interrupt k (0-15) makes it pending under either of two conditions. A secure request (sgi_ns_access_i=0) counts if sgi_ns_cfg_i[k] equals sgi_attr_i. A non-secure request counts only if sgi_ns_cfg_i[k]=1, whatever the value of sgi_attr_i.
- R11: A clear-pending write cannot remove the pending state of a software interrupt. Only an acknowledge or a reset removes it.
- R12: In the cycle where a set-pending write or a rising edge meets an acknowledge or a clear-pending write on the same source, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | NUM_SRC-16 | Peripheral lines for IDs 16 and up, synchronous to clk |
| cfg_i | input | 2*NUM_SRC | Two bits per source; bit 2N+1 selects edge (1) or level (0) |
| wr_valid_i | input | 1 | Software pending-word write strobe |
| wr_clear_i | input | 1 | 0 = set-pending, 1 = clear-pending |
| wr_idx_i | input | WIDX_W | Index of the 32-bit pending word |
| wr_data_i | input | 32 | One bit per source within the word |
| sgi_valid_i | input | 1 | Software-interrupt request strobe |
| sgi_id_i | input | 4 | Software-interrupt ID 0-15 |
| sgi_attr_i | input | 1 | Requested security value (1 = non-secure) |
| sgi_ns_access_i | input | 1 | Request made by a non-secure access |
| sgi_ns_cfg_i | input | 16 | Per software interrupt: 1 = configured non-secure |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | 10 | Acknowledged ID |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_id_i | input | 10 | Completed ID |
| pend_o | output | NUM_SRC | Pending vector |
| act_o | output | NUM_SRC | Active vector |

## Verification
The hardest cases to reach are collisions on the same source in the same clock cycle. One is a rising edge that lands together with an acknowledge or a clear-pending write. Another is a level source being acknowledged while its line is still high, which has to leave the source active and pending rather than only active. Directed sequences set up each collision explicitly. Before the collision cycle, they first bring the source to the required state through a software write. A long random phase then toggles lines, writes, requests and strobes freely, with the trigger modes mixed. After every clock it compares both vectors against a reference model in the bench.

// File: rtl/gic_trk_pkg.sv
// Package: shared constants and the state encoding of a software interrupt.
// Assumes the first NUM_SGI IDs are software-generated and have no line.
package gic_trk_pkg;
    localparam int NUM_SGI  = 16;
    localparam int SGI_ID_W = 4;

    // Encoding is {active, pending}; the cell relies on this bit order.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PEND = 2'b01,
        ST_ACT  = 2'b10,
        ST_ACTP = 2'b11
    } irq_state_e;
endpackage

// File: rtl/gic_trk_decode.sv
// Decoder: turns the write, request, acknowledge and end-of-interrupt
// commands into one strobe per source.
// Assumes the pending words are DATA_W bits wide, with word w covering the
// IDs from DATA_W*w upward.
module gic_trk_decode
    import gic_trk_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ID_W    = 10,
    parameter int DATA_W  = 32,
    parameter int WIDX_W  = 1
) (
    input  logic                    wr_valid_i,
    input  logic                    wr_clear_i,
    input  logic [WIDX_W-1:0]       wr_idx_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    input  logic                    sgi_valid_i,
    input  logic [SGI_ID_W-1:0]     sgi_id_i,
    input  logic                    sgi_attr_i,
    input  logic                    sgi_ns_access_i,
    input  logic [NUM_SGI-1:0]      sgi_ns_cfg_i,
    input  logic                    ack_valid_i,
    input  logic [ID_W-1:0]         ack_id_i,
    input  logic                    eoi_valid_i,
    input  logic [ID_W-1:0]         eoi_id_i,
    output logic [NUM_SRC-1:NUM_SGI] set_o,
    output logic [NUM_SRC-1:NUM_SGI] clr_o,
    output logic [NUM_SGI-1:0]      sgi_o,
    output logic [NUM_SRC-1:0]      ack_o,
    output logic [NUM_SRC-1:0]      eoi_o
);
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        localparam logic [ID_W-1:0] MY_ID = ID_W'(n);

        // Purpose: acknowledge and end-of-interrupt match on the full ID.
        assign ack_o[n] = ack_valid_i && (ack_id_i == MY_ID);
        assign eoi_o[n] = eoi_valid_i && (eoi_id_i == MY_ID);

        if (n < NUM_SGI) begin : g_sgi
            localparam logic [SGI_ID_W-1:0] MY_SGI = SGI_ID_W'(n);
            logic sec_ok;
            // Purpose: a non-secure request ignores its attribute bit.
            assign sec_ok   = sgi_ns_access_i ? sgi_ns_cfg_i[n]
                                              : (sgi_ns_cfg_i[n] == sgi_attr_i);
            assign sgi_o[n] = sgi_valid_i && (sgi_id_i == MY_SGI) && sec_ok;
        end else begin : g_per
            localparam logic [WIDX_W-1:0] MY_WORD = WIDX_W'(n / DATA_W);
            localparam int                MY_BIT  = n % DATA_W;
            logic word_hit;
            // Purpose: select this source's bit in the addressed word.
            assign word_hit = wr_valid_i && (wr_idx_i == MY_WORD) && wr_data_i[MY_BIT];
            assign set_o[n] = word_hit && !wr_clear_i;
            assign clr_o[n] = word_hit &&  wr_clear_i;
        end
    end
endmodule

// File: rtl/gic_trk_sgi_cell.sv
// Cell for one software interrupt: the four-state lifecycle with no line
// input. Pending can be removed only by an acknowledge or by reset.
module gic_trk_sgi_cell
    import gic_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sgi_i,
    input  logic ack_i,
    input  logic eoi_i,
    output logic pend_o,
    output logic act_o
);
    irq_state_e st_q, st_n;

    // Purpose: next state; a new request in the same cycle wins over an acknowledge.
    always_comb begin
        logic a, p;
        a = st_q[1];
        p = st_q[0];
        if (eoi_i) a = 1'b0;
        if (ack_i && p) begin
            a = 1'b1;
            p = 1'b0;
        end
        if (sgi_i) p = 1'b1;
        st_n = irq_state_e'({a, p});
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    assign pend_o = st_q[0];
    assign act_o  = st_q[1];
endmodule

// File: rtl/gic_trk_per_cell.sv
// Cell for one peripheral source. Pending is the OR of a latched bit and,
// in level mode, the live line. Edge mode sets the latch on a rising
// transition sampled on clk. Assumes the line is synchronous to clk.
module gic_trk_per_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic is_edge_i,
    input  logic line_i,
    input  logic set_i,
    input  logic clr_i,
    input  logic ack_i,
    input  logic eoi_i,
    output logic pend_o,
    output logic act_o
);
    logic latch_q, latch_n;
    logic act_q, act_n;
    logic line_q;
    logic rise;

    // Purpose: visible pending and rising-edge detection.
    always_comb begin
        rise   = line_i && !line_q;
        pend_o = latch_q || (!is_edge_i && line_i);
    end

    // Purpose: next latch and active bits; a new event wins over a removal.
    always_comb begin
        latch_n = latch_q;
        act_n   = act_q;
        if (eoi_i) act_n = 1'b0;
        if (ack_i && pend_o) begin
            act_n   = 1'b1;
            latch_n = 1'b0;
        end
        if (clr_i) latch_n = 1'b0;
        if (set_i || (is_edge_i && rise)) latch_n = 1'b1;
    end

    // Purpose: state registers and the previous line sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
            act_q   <= 1'b0;
            line_q  <= 1'b0;
        end else begin
            latch_q <= latch_n;
            act_q   <= act_n;
            line_q  <= line_i;
        end
    end

    assign act_o = act_q;
endmodule

// File: rtl/gic_pend_tracker.sv
// Top: per-source lifecycle tracker. The first NUM_SGI IDs are software
// interrupts and every higher ID is a peripheral line. NUM_SRC must be a
// multiple of DATA_W and larger than NUM_SGI.
module gic_pend_tracker
    import gic_trk_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ID_W    = 10,
    parameter int DATA_W  = 32,
    parameter int NUM_WORDS = NUM_SRC / DATA_W,
    parameter int WIDX_W  = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:NUM_SGI]  line_i,
    input  logic [2*NUM_SRC-1:0]      cfg_i,
    input  logic                      wr_valid_i,
    input  logic                      wr_clear_i,
    input  logic [WIDX_W-1:0]         wr_idx_i,
    input  logic [DATA_W-1:0]         wr_data_i,
    input  logic                      sgi_valid_i,
    input  logic [SGI_ID_W-1:0]       sgi_id_i,
    input  logic                      sgi_attr_i,
    input  logic                      sgi_ns_access_i,
    input  logic [NUM_SGI-1:0]        sgi_ns_cfg_i,
    input  logic                      ack_valid_i,
    input  logic [ID_W-1:0]           ack_id_i,
    input  logic                      eoi_valid_i,
    input  logic [ID_W-1:0]           eoi_id_i,
    output logic [NUM_SRC-1:0]        pend_o,
    output logic [NUM_SRC-1:0]        act_o
);
    logic [NUM_SRC-1:NUM_SGI] set_v, clr_v;
    logic [NUM_SGI-1:0]       sgi_v;
    logic [NUM_SRC-1:0]       ack_v, eoi_v;
    logic [NUM_SRC-1:0]       cfg_unused_bits;
    logic                     unused_cfg;

    gic_trk_decode #(
        .NUM_SRC(NUM_SRC), .ID_W(ID_W), .DATA_W(DATA_W), .WIDX_W(WIDX_W)
    ) u_decode (
        .wr_valid_i      (wr_valid_i),
        .wr_clear_i      (wr_clear_i),
        .wr_idx_i        (wr_idx_i),
        .wr_data_i       (wr_data_i),
        .sgi_valid_i     (sgi_valid_i),
        .sgi_id_i        (sgi_id_i),
        .sgi_attr_i      (sgi_attr_i),
        .sgi_ns_access_i (sgi_ns_access_i),
        .sgi_ns_cfg_i    (sgi_ns_cfg_i),
        .ack_valid_i     (ack_valid_i),
        .ack_id_i        (ack_id_i),
        .eoi_valid_i     (eoi_valid_i),
        .eoi_id_i        (eoi_id_i),
        .set_o           (set_v),
        .clr_o           (clr_v),
        .sgi_o           (sgi_v),
        .ack_o           (ack_v),
        .eoi_o           (eoi_v)
    );

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_cell
        // Purpose: the low bit of each field has no function.
        assign cfg_unused_bits[n] = cfg_i[2*n];
        if (n < NUM_SGI) begin : g_sgi
            gic_trk_sgi_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .sgi_i  (sgi_v[n]),
                .ack_i  (ack_v[n]),
                .eoi_i  (eoi_v[n]),
                .pend_o (pend_o[n]),
                .act_o  (act_o[n])
            );
        end else begin : g_per
            gic_trk_per_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .is_edge_i (cfg_i[2*n+1]),
                .line_i    (line_i[n]),
                .set_i     (set_v[n]),
                .clr_i     (clr_v[n]),
                .ack_i     (ack_v[n]),
                .eoi_i     (eoi_v[n]),
                .pend_o    (pend_o[n]),
                .act_o     (act_o[n])
            );
        end
    end

    // Purpose: gather the configuration bits that software interrupts and field low bits leave unread.
    always_comb begin
        logic acc;
        acc = ^cfg_unused_bits;
        for (int k = 0; k < NUM_SGI; k++) acc = acc ^ cfg_i[2*k+1];
        unused_cfg = acc;
    end
endmodule

// File: rtl/gic_trk_chk.sv
// Checker: temporal properties on the ports of gic_pend_tracker.
module gic_trk_chk
    import gic_trk_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2*NUM_SRC-1:0] cfg_i,
    input logic                 wr_valid_i,
    input logic                 wr_clear_i,
    input logic                 ack_valid_i,
    input logic                 eoi_valid_i,
    input logic [NUM_SRC-1:0]   pend_o,
    input logic [NUM_SRC-1:0]   act_o
);
    logic [NUM_SRC-1:0] edge_mask;
    logic [NUM_SRC-1:0] unused_even;
    logic               unused_chk;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_mask
        assign unused_even[n] = cfg_i[2*n];
        if (n < NUM_SGI) begin : g_s
            assign edge_mask[n] = 1'b0;
        end else begin : g_p
            assign edge_mask[n] = cfg_i[2*n+1];
        end
    end
    assign unused_chk = ^unused_even;

    // R1: the first cycle after reset shows no state.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (act_o == '0) && (pend_o[NUM_SGI-1:0] == '0));

    // R7: a source turns active only after an acknowledge.
    assert_ack_only_activates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(act_o & ~$past(act_o))) |-> $past(ack_valid_i));

    // R7: one acknowledge activates at most one source.
    assert_single_activation_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act_o & ~$past(act_o)) <= 1);

    // R8: an active bit falls only after an end-of-interrupt.
    assert_eoi_only_retires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~act_o & $past(act_o))) |-> $past(eoi_valid_i));

    // R11: pending of a software interrupt falls only after an acknowledge.
    assert_sgi_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~pend_o[NUM_SGI-1:0] & $past(pend_o[NUM_SGI-1:0]))) |-> $past(ack_valid_i));

    // R5: pending of an edge source falls only after an acknowledge or a clear write.
    assert_edge_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~pend_o & $past(pend_o) & $past(edge_mask)))
            |-> ($past(ack_valid_i) || $past(wr_valid_i && wr_clear_i)));
endmodule

bind gic_pend_tracker gic_trk_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_i       (cfg_i),
    .wr_valid_i  (wr_valid_i),
    .wr_clear_i  (wr_clear_i),
    .ack_valid_i (ack_valid_i),
    .eoi_valid_i (eoi_valid_i),
    .pend_o      (pend_o),
    .act_o       (act_o)
);

// File: tb/gic_pend_tracker_tb.sv
module gic_pend_tracker_tb;
    localparam int N = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   line = '0;
    logic [2*N-1:0] cfg = '0;
    logic           wr_valid = 0, wr_clear = 0;
    logic [0:0]     wr_idx = '0;
    logic [31:0]    wr_data = '0;
    logic           sgi_valid = 0, sgi_attr = 0, sgi_ns = 0;
    logic [3:0]     sgi_id = '0;
    logic [15:0]    sgi_cfg = '0;
    logic           ack_valid = 0, eoi_valid = 0;
    logic [9:0]     ack_id = '0, eoi_id = '0;
    logic [N-1:0]   pend_o, act_o;

    logic [N-1:0]   m_p = '0, m_a = '0, m_lq = '0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gic_pend_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .line_i(line[N-1:16]), .cfg_i(cfg),
        .wr_valid_i(wr_valid), .wr_clear_i(wr_clear), .wr_idx_i(wr_idx),
        .wr_data_i(wr_data), .sgi_valid_i(sgi_valid), .sgi_id_i(sgi_id),
        .sgi_attr_i(sgi_attr), .sgi_ns_access_i(sgi_ns), .sgi_ns_cfg_i(sgi_cfg),
        .ack_valid_i(ack_valid), .ack_id_i(ack_id), .eoi_valid_i(eoi_valid),
        .eoi_id_i(eoi_id), .pend_o(pend_o), .act_o(act_o)
    );

    function automatic logic [N-1:0] model_pend();
        logic [N-1:0] v;
        for (int n = 0; n < N; n++)
            v[n] = m_p[n] | ((n >= 16) && !cfg[2*n+1] && line[n]);
        return v;
    endfunction

    // Reference model step, from the requirements, with the inputs before the clock edge.
    task automatic model_step();
        logic [N-1:0] pv, np, na;
        pv = model_pend();
        np = m_p;
        na = m_a;
        for (int n = 0; n < N; n++) begin
            logic ackn, hit;
            ackn = ack_valid && (ack_id == 10'(n)) && pv[n];
            if (eoi_valid && (eoi_id == 10'(n))) na[n] = 1'b0;
            if (ackn) begin na[n] = 1'b1; np[n] = 1'b0; end
            if (n < 16) begin
                if (sgi_valid && sgi_id == 4'(n) &&
                    (sgi_ns ? sgi_cfg[n] : (sgi_cfg[n] == sgi_attr))) np[n] = 1'b1;
            end else begin
                hit = wr_valid && (wr_idx == 1'(n / 32)) && wr_data[n % 32];
                if (hit && wr_clear) np[n] = 1'b0;
                if ((hit && !wr_clear) || (cfg[2*n+1] && line[n] && !m_lq[n])) np[n] = 1'b1;
            end
        end
        m_p = np;
        m_a = na;
        m_lq = line;
    endtask

    task automatic report(string tag, logic [N-1:0] got, logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic chk1(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    // One clock: update the model, cross the edge, compare, drop strobes.
    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        report("R7 model pend", pend_o, model_pend());
        report("R8 model act", act_o, m_a);
        wr_valid = 0; sgi_valid = 0; ack_valid = 0; eoi_valid = 0;
    endtask

    task automatic wr(bit clr, int id);
        wr_valid = 1; wr_clear = clr; wr_idx = 1'(id / 32);
        wr_data = 32'h1 << (id % 32);
    endtask
    task automatic ack(int id); ack_valid = 1; ack_id = 10'(id); endtask
    task automatic eoi(int id); eoi_valid = 1; eoi_id = 10'(id); endtask
    task automatic sgi(int id, bit ns, bit attr);
        sgi_valid = 1; sgi_id = 4'(id); sgi_ns = ns; sgi_attr = attr;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        cfg[2*20+1] = 1; cfg[2*40+1] = 1; cfg[2*22] = 1;
        repeat (3) @(negedge clk);
        report("R1 reset pend", pend_o, '0);
        report("R1 reset act", act_o, '0);
        rst_n = 1;
        step();
        report("R1 idle pend", pend_o, '0);

        // R2 / R5: edge source 20
        line[20] = 1; step();
        chk1("R2 edge sets pend", pend_o[20], 1);
        wr(1, 20); step();
        chk1("R5 edge clear", pend_o[20], 0);
        step(); step();
        chk1("R2 held line no repend", pend_o[20], 0);
        line[20] = 0; step();

        // R3 / R6 / R7 / R8: level source 21
        line[21] = 1; step();
        chk1("R3 level pend", pend_o[21], 1);
        wr(1, 21); step();
        chk1("R6 level clear keeps line pend", pend_o[21], 1);
        ack(21); step();
        chk1("R7 level ack act", act_o[21], 1);
        chk1("R7 level ack still pend", pend_o[21], 1);
        line[21] = 0; #1;
        chk1("R3 level drop comb", pend_o[21], 0);
        eoi(21); step();
        chk1("R8 eoi act->inactive", act_o[21], 0);

        // R4 / R6 / R8: software latch on level source 41
        wr(0, 41); step();
        chk1("R4 set pend", pend_o[41], 1);
        wr(1, 41); step();
        chk1("R6 clear sw latch", pend_o[41], 0);
        wr(0, 41); step();
        ack(41); step();
        chk1("R7 ack act", act_o[41], 1);
        chk1("R7 ack clears pend", pend_o[41], 0);
        wr(0, 41); step();
        chk1("R4 set on active", pend_o[41], 1);
        eoi(41); step();
        chk1("R8 actp->pend act", act_o[41], 0);
        chk1("R8 actp->pend pend", pend_o[41], 1);
        ack(41); step(); eoi(41); step();

        // R5: edge source 40 in active state
        wr(0, 40); step(); ack(40); step();
        line[40] = 1; step();
        chk1("R2 edge on active", pend_o[40], 1);
        wr(1, 40); step();
        chk1("R5 actp->act pend", pend_o[40], 0);
        chk1("R5 actp->act act", act_o[40], 1);
        eoi(40); step();
        wr(1, 40); step();
        report("R5 clear non-pending no effect", {pend_o[40], act_o[40]}, '0);
        line[40] = 0; step();

        // R7: acknowledges that must do nothing
        ack(50); step();
        ack(1023); step();
        report("R7 void ack", act_o, '0);

        // R12: collisions
        wr(0, 20); step();
        line[20] = 1; ack(20); step();
        chk1("R12 edge with ack act", act_o[20], 1);
        chk1("R12 edge with ack pend", pend_o[20], 1);
        eoi(20); step();
        line[20] = 0; step();
        line[20] = 1; wr(1, 20); step();
        chk1("R12 edge with clear", pend_o[20], 1);
        wr(1, 20); step();
        line[20] = 0; step();

        // R9: low field bit has no effect
        line[22] = 1; step();
        chk1("R9 level via bit 2N+1", pend_o[22], 1);
        line[22] = 0; #1;
        chk1("R9 level drop", pend_o[22], 0);

        // R10: security qualification
        sgi_cfg = 16'h0220;
        sgi(3, 0, 0); step();
        chk1("R10 secure match", pend_o[3], 1);
        sgi(5, 0, 0); step();
        chk1("R10 secure mismatch", pend_o[5], 0);
        sgi(5, 0, 1); step();
        chk1("R10 secure ns match", pend_o[5], 1);
        sgi(7, 1, 1); step();
        chk1("R10 ns on secure sgi", pend_o[7], 0);
        sgi(9, 1, 0); step();
        chk1("R10 ns attr ignored", pend_o[9], 1);

        // R11 / R4: software interrupts ignore pending words
        wr_valid = 1; wr_clear = 1; wr_idx = 0; wr_data = '1; step();
        report("R11 clear ignored", {48'b0, pend_o[15:0]}, 64'h0228);
        wr_valid = 1; wr_clear = 0; wr_idx = 0; wr_data = 32'h0000_FFFF; step();
        report("R4 low ids ignored", {48'b0, pend_o[15:0]}, 64'h0228);
        ack(3); step();
        chk1("R11 ack removes", pend_o[3], 0);
        chk1("R11 ack activates", act_o[3], 1);
        eoi(3); step();

        // Random phase against the model
        for (int k = 0; k < 2 * N; k++) cfg[k] = 1'($urandom);
        for (int c = 0; c < 4000; c++) begin
            for (int n = 16; n < N; n++) if ($urandom % 16 == 0) line[n] = ~line[n];
            if ($urandom % 4 == 0) begin
                wr_valid = 1; wr_clear = 1'($urandom); wr_idx = 1'($urandom);
                wr_data = $urandom & $urandom;
            end
            if ($urandom % 4 == 0) sgi(int'($urandom % 16), 1'($urandom), 1'($urandom));
            if ($urandom % 8 == 0) sgi_cfg = 16'($urandom);
            if ($urandom % 3 == 0) ack(int'($urandom % 72));
            if ($urandom % 3 == 0) eoi(int'($urandom % 72));
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule